// File: doc/BRIEF.md
# Field-Selectable Add/Subtract Unit with Shared Carry

This block is the integer add/subtract datapath of a small 32-bit processor. It runs six operations: plain add, add with carry, subtract, subtract with carry, reverse subtract and reverse subtract with carry. One carry flag serves all six. Each source and the destination can name one byte, one halfword or the whole register. The operation width is the width of the destination field, and carry is taken at that width. Software can therefore chain byte or halfword steps to build wider arithmetic.

The flag has two meanings. The add family reads it as a true carry. The subtract family reads it as an inverted borrow: a set flag means no borrow. An add followed by a subtract-with-carry is well defined but easy to misread. After an add that did not overflow, the subtract-with-carry takes one extra away. After an add that did overflow, it takes nothing extra.

The result is combinational. The caller passes in the current destination register value, and the block returns that value with only the selected field replaced. The carry flag is a register that loads on the clock edge.

Top module: `arith_carry_unit`

## Requirements
- R1: Field selects use a 3-bit code: 0 to 3 pick byte 0 to 3 (bits 8k+7:8k), 4 picks halfword 0 (bits 15:0), 5 picks halfword 1 (bits 31:16), and 6 or 7 pick the whole 32-bit word. Source fields are zero-extended and then cut to the width of the destination field.
- R2: Opcode 0 (add) computes a+b at the destination width and sets the carry flag exactly when the unsigned sum does not fit that width.
- R3: Opcode 1 (add with carry) computes a+b+flag and sets the flag on unsigned overflow of the destination width.
- R4: Opcode 2 (subtract) computes a+~b+1. The flag becomes 1 when a>=b (no borrow) and 0 when a borrow occurs.
- R5: Opcode 3 (subtract with carry) computes a+~b+flag. It subtracts one extra when the flag is 0 and nothing extra when the flag is 1. The new flag is 1 exactly when no borrow occurred.
- R6: Opcodes 4 and 5 (reverse subtract, with and without carry) behave like opcodes 2 and 3 with the two source operands swapped.
- R7: A subtract on byte 0 followed by a subtract-with-carry on byte 1 yields the same halfword as a single 16-bit subtract, both with and without a borrow between the bytes (0x0100-0x0001 gives 0x00FF, and 0x0102-0x0001 gives 0x0101).
- R8: Only the destination field of dst_new takes the result. Every other bit equals dst_old.
- R9: With op_valid low, or with an opcode from 6 to 15, dst_new equals dst_old and the carry flag keeps its value.
- R10: The carry flag is 0 after reset. It takes its new value on the rising clock edge that follows the operation.
- R11: With use_imm high, the second operand is the 8-bit immediate, zero-extended, and src_b and sel_b are ignored.
- R12: On 32-bit fields, adding 1 to 0xFFFFFFFE and then subtracting 0 with carry gives 0xFFFFFFFE. Adding 1 to 0xFFFFFFFF and then subtracting 0 with carry gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (0..5 arithmetic) |
| src_a | input | 32 | First source register value |
| sel_a | input | 3 | Field select for the first source |
| src_b | input | 32 | Second source register value |
| sel_b | input | 3 | Field select for the second source |
| use_imm | input | 1 | Use the immediate as the second operand |
| imm_val | input | 8 | Immediate value |
| sel_d | input | 3 | Destination field select, which sets the operation width |
| dst_old | input | 32 | Current destination register value |
| dst_new | output | 32 | Destination value with the selected field replaced |
| carry_flag | output | 1 | Registered shared carry flag |

## Verification
The directed patterns come first. They cover the two add-then-subtract-with-carry corner cases, which separate a true-carry reading of the flag from an inverted-borrow reading. They also cover the byte-chained subtract with and without an inter-byte borrow, which shows whether carry is taken at the field width. Reverse-subtract cases with unequal operands reveal any swap error. Immediate cases with a non-zero src_b show whether the immediate path is honoured. A long stream of random opcodes, field selects and operands follows, including out-of-range opcodes and idle cycles. It checks every cycle against a behavioural model that subtracts with signed arithmetic rather than adding an inverted operand.

// File: rtl/arith_pkg.sv
`timescale 1ns/1ps
package arith_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned OPC_W  = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SUC = 4'd3,
    OP_RSB = 4'd4,
    OP_RSC = 4'd5
  } arith_op_e;

  typedef enum logic [SEL_W-1:0] {
    FS_B0 = 3'd0,
    FS_B1 = 3'd1,
    FS_B2 = 3'd2,
    FS_B3 = 3'd3,
    FS_H0 = 3'd4,
    FS_H1 = 3'd5,
    FS_W  = 3'd6
  } field_sel_e;

  function automatic logic [4:0] fs_offset(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    fs_offset = 5'd8;
      3'd2:    fs_offset = 5'd16;
      3'd3:    fs_offset = 5'd24;
      3'd5:    fs_offset = 5'd16;
      default: fs_offset = 5'd0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] fs_mask(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0, 3'd1, 3'd2, 3'd3: fs_mask = WORD_W'((1 << BYTE_W) - 1);
      3'd4, 3'd5:             fs_mask = WORD_W'((1 << HALF_W) - 1);
      default:                fs_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/arith_field_get.sv
`timescale 1ns/1ps
module arith_field_get
  import arith_pkg::*;
(
  input  logic [WORD_W-1:0] reg_val,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] field_val
);
  always_comb begin
    field_val = (reg_val >> fs_offset(sel)) & fs_mask(sel);
  end
endmodule

// File: rtl/arith_addsub.sv
`timescale 1ns/1ps
module arith_addsub
  import arith_pkg::*;
(
  input  logic [OPC_W-1:0]  op_code,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic [SEL_W-1:0]  sel_d,
  input  logic              flag_in,
  output logic [WORD_W-1:0] result,
  output logic              flag_out,
  output logic              is_arith
);
  logic [WORD_W-1:0] wmask, x_op, y_op, y_eff;
  logic [WORD_W:0]   sum;
  logic              swap_ops, is_sub, take_flag, cin;

  always_comb begin
    wmask     = fs_mask(sel_d);
    is_arith  = (op_code <= OP_RSC);
    swap_ops  = (op_code == OP_RSB) || (op_code == OP_RSC);
    is_sub    = (op_code == OP_SUB) || (op_code == OP_SUC) || swap_ops;
    take_flag = (op_code == OP_ADC) || (op_code == OP_SUC) || (op_code == OP_RSC);
    x_op      = (swap_ops ? opnd_b : opnd_a) & wmask;
    y_op      = (swap_ops ? opnd_a : opnd_b) & wmask;
    y_eff     = is_sub ? (~y_op & wmask) : y_op;
    cin       = take_flag ? flag_in : is_sub;
    sum       = {1'b0, x_op} + {1'b0, y_eff} + {{WORD_W{1'b0}}, cin};
    result    = sum[WORD_W-1:0] & wmask;
    case (sel_d)
      3'd0, 3'd1, 3'd2, 3'd3: flag_out = sum[BYTE_W];
      3'd4, 3'd5:             flag_out = sum[HALF_W];
      default:                flag_out = sum[WORD_W];
    endcase
  end
endmodule

// File: rtl/arith_field_put.sv
`timescale 1ns/1ps
module arith_field_put
  import arith_pkg::*;
(
  input  logic [WORD_W-1:0] reg_old,
  input  logic [WORD_W-1:0] field_val,
  input  logic [SEL_W-1:0]  sel,
  output logic [WORD_W-1:0] reg_new
);
  logic [WORD_W-1:0] place_mask;
  always_comb begin
    place_mask = fs_mask(sel) << fs_offset(sel);
    reg_new    = (reg_old & ~place_mask) | ((field_val & fs_mask(sel)) << fs_offset(sel));
  end
endmodule

// File: rtl/arith_carry_unit.sv
`timescale 1ns/1ps
module arith_carry_unit
  import arith_pkg::*;
#(
  parameter int unsigned IMM_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [WORD_W-1:0] src_a,
  input  logic [SEL_W-1:0]  sel_a,
  input  logic [WORD_W-1:0] src_b,
  input  logic [SEL_W-1:0]  sel_b,
  input  logic              use_imm,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic [SEL_W-1:0]  sel_d,
  input  logic [WORD_W-1:0] dst_old,
  output logic [WORD_W-1:0] dst_new,
  output logic              carry_flag
);
  localparam int unsigned IMM_PAD = WORD_W - IMM_W;

  logic [WORD_W-1:0] fld_a, fld_b, opnd_b, core_res, merged;
  logic              core_flag, core_arith, flag_en, flag_d;

  arith_field_get u_get_a (.reg_val(src_a), .sel(sel_a), .field_val(fld_a));
  arith_field_get u_get_b (.reg_val(src_b), .sel(sel_b), .field_val(fld_b));

  always_comb begin
    opnd_b = use_imm ? {{IMM_PAD{1'b0}}, imm_val} : fld_b;
  end

  arith_addsub u_core (
    .op_code (op_code),
    .opnd_a  (fld_a),
    .opnd_b  (opnd_b),
    .sel_d   (sel_d),
    .flag_in (carry_flag),
    .result  (core_res),
    .flag_out(core_flag),
    .is_arith(core_arith)
  );

  arith_field_put u_put (
    .reg_old  (dst_old),
    .field_val(core_res),
    .sel      (sel_d),
    .reg_new  (merged)
  );

  // next-state and write enable
  always_comb begin
    flag_en = op_valid && core_arith;
    flag_d  = flag_en ? core_flag : carry_flag;
    dst_new = flag_en ? merged : dst_old;
  end

  // carry register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_flag <= 1'b0;
    else if (flag_en) carry_flag <= flag_d;
  end

  // R9: flag holds when nothing arithmetic is presented
  assert_carry_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && (op_code <= OP_RSC)) |=> carry_flag == $past(carry_flag));

  // R2: adding a zero register never carries
  assert_add_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_ADD && !use_imm && src_b == '0) |=> !carry_flag);

  // R4: subtracting a zero register never borrows
  assert_sub_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_SUB && !use_imm && src_b == '0) |=> carry_flag);

  // R6: reverse subtract with a zero first source never borrows
  assert_rsb_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_RSB && src_a == '0) |=> carry_flag);

  // R8: a byte-0 write keeps the upper bytes
  assert_keep_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && sel_d == FS_B0) |-> dst_new[WORD_W-1:BYTE_W] == dst_old[WORD_W-1:BYTE_W]);
endmodule

// File: tb/sim_arith_carry_unit.sv
`timescale 1ns/1ps
module sim_arith_carry_unit;
  logic        clk, rst_n, op_valid, use_imm, carry_flag;
  logic [3:0]  op_code;
  logic [31:0] src_a, src_b, dst_old, dst_new;
  logic [2:0]  sel_a, sel_b, sel_d;
  logic [7:0]  imm_val;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit mc;
  logic [31:0] last_dst;

  arith_carry_unit u0 (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic longint fget(input logic [31:0] v, input logic [2:0] s);
    case (s)
      0,1,2,3: return (longint'(v) >> (8*s)) & 64'hFF;
      4:       return longint'(v) & 64'hFFFF;
      5:       return (longint'(v) >> 16) & 64'hFFFF;
      default: return longint'(v);
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input bit v, input logic [3:0] op,
                        input logic [31:0] a, input logic [2:0] sa,
                        input logic [31:0] b, input logic [2:0] sb,
                        input bit ui, input logic [7:0] im,
                        input logic [31:0] dold, input logic [2:0] sd);
    int w, off;
    longint x, y, s, msk;
    bit nc, cin;
    logic [31:0] nd;
    @(negedge clk);
    op_valid = v; op_code = op; src_a = a; sel_a = sa; src_b = b; sel_b = sb;
    use_imm = ui; imm_val = im; dst_old = dold; sel_d = sd;
    w   = (sd < 4) ? 8 : (sd < 6) ? 16 : 32;
    off = (sd < 4) ? 8*sd : (sd == 5) ? 16 : 0;
    msk = (64'd1 << w) - 1;
    x = fget(a, sa) & msk;
    y = (ui ? longint'(im) : fget(b, sb)) & msk;
    nd = dold; nc = mc;
    if (v && op <= 5) begin
      if (op == 4 || op == 5) begin s = x; x = y; y = s; end
      if (op <= 1) begin
        s  = x + y + ((op == 1) ? longint'(mc) : 0);
        nc = ((s >> w) & 1) != 0;
      end else begin
        cin = (op == 3 || op == 5) ? mc : 1'b1;
        s  = x - y - (cin ? 0 : 1);
        nc = (s >= 0);
      end
      s = s & msk;
      for (int i = 0; i < w; i++) nd[off+i] = s[i];
    end
    #1;
    chk({req, " dst"}, dst_new, nd);
    last_dst = dst_new;
    @(posedge clk); #1;
    mc = nc;
    chk({req, " carry"}, {31'd0, carry_flag}, {31'd0, mc});
  endtask

  initial begin
    #(4*200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_valid = 0; op_code = 0; src_a = 0; src_b = 0; sel_a = 6; sel_b = 6;
    sel_d = 6; use_imm = 0; imm_val = 0; dst_old = 0; mc = 0;
    #1;
    chk("R10 reset", {31'd0, carry_flag}, 32'd0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R12 corner cases (ADD then SUC on words)
    run_op("R2", 1, 0, 32'hFFFFFFFE, 6, 32'd1, 6, 0, 0, 0, 6);
    chk("R12 add no carry", {31'd0, carry_flag}, 32'd0);
    run_op("R5", 1, 3, last_dst, 6, 32'd0, 6, 0, 0, 0, 6);
    chk("R12 suc after add", last_dst, 32'hFFFFFFFE);
    run_op("R2", 1, 0, 32'hFFFFFFFF, 6, 32'd1, 6, 0, 0, 0, 6);
    chk("R12 add carry", {31'd0, carry_flag}, 32'd1);
    run_op("R5", 1, 3, last_dst, 6, 32'd0, 6, 0, 0, 0, 6);
    chk("R12 suc after carry", last_dst, 32'h00000000);

    // R7 byte chain with borrow
    run_op("R4", 1, 2, 32'h0100, 0, 32'h0001, 0, 0, 0, 32'h0, 0);
    run_op("R7", 1, 3, 32'h0100, 1, 32'h0001, 1, 0, 0, last_dst, 1);
    chk("R7 chain borrow", last_dst, 32'h00FF);
    // R7 byte chain without borrow
    run_op("R4", 1, 2, 32'h0102, 0, 32'h0001, 0, 0, 0, 32'h0, 0);
    run_op("R7", 1, 3, 32'h0102, 1, 32'h0001, 1, 0, 0, last_dst, 1);
    chk("R7 chain no borrow", last_dst, 32'h0101);

    // R3 ADC chain on halfwords
    run_op("R3", 1, 0, 32'h0000FFFF, 4, 32'h00000001, 4, 0, 0, 32'hAAAAAAAA, 4);
    run_op("R3", 1, 1, 32'h00010000, 5, 32'h00000000, 5, 0, 0, last_dst, 5);
    chk("R3 adc chain", last_dst, 32'h00020000);

    // R6 reverse subtract
    run_op("R6", 1, 4, 32'd5, 6, 32'd9, 6, 0, 0, 0, 6);
    chk("R6 rsb value", last_dst, 32'd4);
    run_op("R6", 1, 5, 32'd9, 6, 32'd5, 6, 0, 0, 0, 6);

    // R11 immediate replaces src_b
    run_op("R11", 1, 0, 32'h12, 0, 32'hFFFFFFFF, 0, 1, 8'h05, 32'h11223344, 2);
    chk("R11 imm", last_dst, 32'h11173344);

    // R9 ignored operations
    run_op("R9", 0, 0, 32'hFFFFFFFF, 6, 32'd1, 6, 0, 0, 32'hDEADBEEF, 6);
    run_op("R9", 1, 4'd9, 32'hFFFFFFFF, 6, 32'd1, 6, 0, 0, 32'hCAFEF00D, 6);
    chk("R9 bad opcode", last_dst, 32'hCAFEF00D);

    // R1 R8 random stream
    for (int k = 0; k < 600; k++) begin
      run_op("R1 R8 random", ($urandom % 10) != 0, 4'($urandom % 10),
             $urandom, 3'($urandom), $urandom, 3'($urandom),
             ($urandom % 4) == 0, 8'($urandom), $urandom, 3'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule